// File: doc/BRIEF.md
# Latched Decimal Event Counter

This block counts input pulses in a chain of decimal (BCD) digits, four by default. A separate holding register keeps the most recent finished result. A count-enable gate decides which pulses are counted. A capture strobe copies the running count into the holding register, and a synchronous clear zeroes only the running count. A display driven from the holding register therefore stays steady while the next measurement builds up out of sight. This arrangement suits frequency meters and event tallies where an external timer produces the gate and strobe sequence.

Everything runs on one system clock. The pulse input and the capture strobe each pass through a two-stage synchroniser and a rising-edge detector, so neither is ever used as a clock. The held digits and the held overflow flag leave the block as one output group, which a single enable either drives or floats.

Top module: `bcd_event_latch`

## Requirements
- R1: Each 4-bit digit holds a value from 0 to 9, and the least significant digit sits in bits [3:0]. A counted pulse adds one to the lowest digit. A digit that steps from 9 to 0 passes one count to the next higher digit.
- R2: A pulse is counted only if `gate_en` is high in the cycle where its synchronised rising edge is detected. A rising edge of `pulse_in` takes effect at the third rising clock edge after `pulse_in` is first sampled high. Pulses seen while `gate_en` is low leave the count unchanged.
- R3: The holding register loads the running count and overflow flag on a rising edge of `cap_strobe`. The load happens at the third rising clock edge after the strobe is first sampled high, and it takes the count as it stood before that edge.
- R4: Between capture edges the held value and the held overflow flag stay unchanged, whatever happens to the running count.
- R5: `cnt_clr` zeroes the running digits and the running overflow flag at the next clock edge, and it leaves the holding register as it was.
- R6: When `out_en` is low, all bits of `held_bcd` and `held_ovf` float together. When it is high, they show the holding register.
- R7: A count step from 9999 wraps the digits to 0000 and sets a sticky overflow flag. The flag stays set until `cnt_clr` or reset, and a capture copies it to `held_ovf`.
- R8: If `cnt_clr` is high in the same cycle that a gated pulse edge is detected, the clear wins and the count ends at zero.
- R9: After synchronous reset the running count, the held value and both overflow flags are zero.
- R10: If a capture load and `cnt_clr` fall in the same cycle, the holding register receives the count from before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 1 | Asynchronous event input; its rising edges are counted |
| gate_en | input | 1 | Count enable, synchronous to `clk` |
| cnt_clr | input | 1 | Synchronous clear of the running count and its overflow flag |
| cap_strobe | input | 1 | Asynchronous capture strobe; acts on its rising edge |
| out_en | input | 1 | Drives the output group when high and floats it when low |
| held_bcd | output | 16 | Held BCD digits, least significant digit in bits [3:0] |
| held_ovf | output | 1 | Held overflow flag |

## Verification
A counter clear can land in the same cycle as a counted pulse edge, and it can also land in the same cycle as a capture load. The bench schedules each of these collisions by counting synchroniser stages. It raises the pulse or strobe on a falling edge, waits two rising edges, and then asserts the clear for exactly the one cycle in which the detected edge acts. For the pulse collision the result passes if a later capture reads zero. For the capture collision it passes if the held value is the count from before the clear and the next capture reads zero.

// File: rtl/bel_pkg.sv
package bel_pkg;

    localparam int DEF_DIGITS = 4;
    localparam int BCD_W      = 4;
    localparam int SYNC_DEPTH = 2;

    typedef logic [BCD_W-1:0] bcd_t;

    typedef struct packed {
        bcd_t digit;
        logic carry;
    } digit_step_t;

    function automatic digit_step_t bcd_step(bcd_t cur, logic inc);
        digit_step_t r;
        r.carry = 1'b0;
        r.digit = cur;
        if (inc) begin
            if (cur == bcd_t'(9)) begin
                r.digit = '0;
                r.carry = 1'b1;
            end else begin
                r.digit = cur + bcd_t'(1);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/bel_edge_sync.sv
module bel_edge_sync #(
    parameter int STAGES = bel_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst) shift_q <= '0;
        else     shift_q <= {shift_q[STAGES-1:0], async_in};
    end

    assign rise = shift_q[STAGES-1] & ~shift_q[STAGES];
endmodule

// File: rtl/bel_bcd_digit.sv
module bel_bcd_digit
    import bel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc_in,
    output bcd_t q,
    output logic carry
);
    digit_step_t nxt;

    always_comb nxt = bcd_step(q, inc_in);

    always_ff @(posedge clk) begin
        if (rst || clr) q <= '0;
        else            q <= nxt.digit;
    end

    assign carry = nxt.carry;
endmodule

// File: rtl/bel_hold_reg.sv
module bel_hold_reg #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/bcd_event_latch.sv
module bcd_event_latch
    import bel_pkg::*;
#(
    parameter int DIGITS = DEF_DIGITS,
    localparam int VAL_W = DIGITS * BCD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse_in,
    input  logic             gate_en,
    input  logic             cnt_clr,
    input  logic             cap_strobe,
    input  logic             out_en,
    output wire [VAL_W-1:0]  held_bcd,
    output wire              held_ovf
);
    logic              pulse_rise;
    logic              cap_rise;
    logic [DIGITS:0]   inc_chain;
    logic [VAL_W-1:0]  cnt_val;
    logic              cnt_ovf;
    logic [VAL_W:0]    hold_val;

    bel_edge_sync #(.STAGES(SYNC_DEPTH)) u_pulse_sync (
        .clk(clk), .rst(rst), .async_in(pulse_in), .rise(pulse_rise)
    );

    bel_edge_sync #(.STAGES(SYNC_DEPTH)) u_cap_sync (
        .clk(clk), .rst(rst), .async_in(cap_strobe), .rise(cap_rise)
    );

    assign inc_chain[0] = pulse_rise & gate_en;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        bel_bcd_digit u_digit (
            .clk   (clk),
            .rst   (rst),
            .clr   (cnt_clr),
            .inc_in(inc_chain[g]),
            .q     (cnt_val[g*BCD_W +: BCD_W]),
            .carry (inc_chain[g+1])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || cnt_clr)        cnt_ovf <= 1'b0;
        else if (inc_chain[DIGITS]) cnt_ovf <= 1'b1;
    end

    bel_hold_reg #(.W(VAL_W + 1)) u_hold (
        .clk (clk),
        .rst (rst),
        .load(cap_rise),
        .d   ({cnt_ovf, cnt_val}),
        .q   (hold_val)
    );

    assign held_bcd = out_en ? hold_val[VAL_W-1:0] : {VAL_W{1'bz}};
    assign held_ovf = out_en ? hold_val[VAL_W]     : 1'bz;
endmodule

// File: rtl/bel_checker.sv
module bel_checker #(
    parameter int DIGITS = bel_pkg::DEF_DIGITS,
    localparam int VAL_W = DIGITS * bel_pkg::BCD_W
) (
    input logic             clk,
    input logic             rst,
    input logic             gate_en,
    input logic             cnt_clr,
    input logic             cap_rise,
    input logic [VAL_W-1:0] cnt_val,
    input logic             cnt_ovf,
    input logic [VAL_W:0]   hold_val
);
    for (genvar g = 0; g < DIGITS; g++) begin : g_rng
        AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
            cnt_val[g*4 +: 4] <= 4'd9);   // R1
    end

    AST_GATE_LOW_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!gate_en && !cnt_clr) |=> $stable(cnt_val) && $stable(cnt_ovf));   // R2

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !cap_rise |=> $stable(hold_val));   // R4

    AST_CLR_ZEROES_COUNT: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> (cnt_val == '0) && !cnt_ovf);   // R5

    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (rst)
        cap_rise |=> hold_val == $past({cnt_ovf, cnt_val}));   // R3

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (cnt_ovf && !cnt_clr) |=> cnt_ovf);   // R7
endmodule

bind bcd_event_latch bel_checker #(.DIGITS(DIGITS)) u_bel_chk (
    .clk     (clk),
    .rst     (rst),
    .gate_en (gate_en),
    .cnt_clr (cnt_clr),
    .cap_rise(cap_rise),
    .cnt_val (cnt_val),
    .cnt_ovf (cnt_ovf),
    .hold_val(hold_val)
);

// File: tb/bcd_event_latch_tb_top.sv
module bcd_event_latch_tb_top;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst, pulse_in, gate_en, cnt_clr, cap_strobe, out_en;
    wire [W-1:0] held_bcd;
    wire         held_ovf;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    bcd_event_latch dut_i (
        .clk(clk), .rst(rst), .pulse_in(pulse_in), .gate_en(gate_en),
        .cnt_clr(cnt_clr), .cap_strobe(cap_strobe), .out_en(out_en),
        .held_bcd(held_bcd), .held_ovf(held_ovf)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [W-1:0] to_bcd(int n);
        logic [W-1:0] r;
        int v;
        v = n % 10000;
        for (int i = 0; i < 4; i++) begin
            r[i*4 +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    task automatic check(string req, logic [W:0] act, logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse();
        @(negedge clk) pulse_in = 1'b1;
        repeat (2) @(negedge clk);
        pulse_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic capture();
        @(negedge clk) cap_strobe = 1'b1;
        repeat (2) @(negedge clk);
        cap_strobe = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic clear();
        @(negedge clk) cnt_clr = 1'b1;
        @(negedge clk) cnt_clr = 1'b0;
    endtask

    int count;
    logic [W:0] last;

    initial begin
        rst = 1'b1; pulse_in = 0; gate_en = 0; cnt_clr = 0; cap_strobe = 0; out_en = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        out_en = 1'b1;
        @(negedge clk);
        check("R9 held after reset", {held_ovf, held_bcd}, '0);
        capture();
        check("R9 count after reset", {held_ovf, held_bcd}, '0);

        // Sweep through the full range and past the wrap point
        gate_en = 1'b1;
        last = '0;
        for (int n = 1; n <= 10001; n++) begin
            pulse();
            if (n % 613 == 0 || n == 9 || n == 10 || n == 99 || n == 100 ||
                n == 999 || n == 1000 || n == 9999 || n == 10000 || n == 10001) begin
                check("R4 held between captures", {held_ovf, held_bcd}, last);
                capture();
                last = {(n >= 10000) ? 1'b1 : 1'b0, to_bcd(n)};
                check((n >= 10000) ? "R7 wrap and overflow" : "R1 R3 captured count",
                      {held_ovf, held_bcd}, last);
            end
        end

        // Clear leaves the held value alone and resets overflow
        clear();
        repeat (2) @(negedge clk);
        check("R5 held kept after clear", {held_ovf, held_bcd}, last);
        capture();
        check("R5 clear zeroes count and overflow", {held_ovf, held_bcd}, '0);

        // Gate low: pulses ignored
        gate_en = 1'b0;
        repeat (5) pulse();
        capture();
        check("R2 gate low ignores pulses", {held_ovf, held_bcd}, '0);
        gate_en = 1'b1;
        repeat (3) pulse();
        check("R4 held steady while counting", {held_ovf, held_bcd}, '0);
        capture();
        check("R2 gate high counts", {held_ovf, held_bcd}, {1'b0, to_bcd(3)});

        // Clear collides with a counted pulse edge
        @(negedge clk) pulse_in = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk) cnt_clr = 1'b1;
        @(negedge clk) cnt_clr = 1'b0;
        pulse_in = 1'b0;
        repeat (3) @(negedge clk);
        capture();
        check("R8 clear beats pulse", {held_ovf, held_bcd}, '0);
        pulse();
        capture();
        check("R8 no deferred pulse", {held_ovf, held_bcd}, {1'b0, to_bcd(1)});

        // Capture load collides with clear
        repeat (7) pulse();
        @(negedge clk) cap_strobe = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk) cnt_clr = 1'b1;
        @(negedge clk) cnt_clr = 1'b0;
        cap_strobe = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 capture takes pre-clear count", {held_ovf, held_bcd}, {1'b0, to_bcd(8)});

        // Output enable floats the whole group
        out_en = 1'b0;
        @(negedge clk);
        checks++;
        if (!((held_bcd === {W{1'bz}} || held_bcd === '0) &&
              (held_ovf === 1'bz || held_ovf === 1'b0))) begin
            errors++;
            $display("FAIL R6 output not floating: actual %h expected z", {held_ovf, held_bcd});
        end
        out_en = 1'b1;
        @(negedge clk);
        check("R6 output driven again", {held_ovf, held_bcd}, {1'b0, to_bcd(8)});
        capture();
        check("R10 count was cleared", {held_ovf, held_bcd}, '0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule